// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Port

This block gathers up to 32 peripheral interrupt lines and drives a single interrupt request toward a processor. At build time, each line is set up either as edge-triggered, where a rising transition is latched until software clears it, or as level-sensitive, where the captured bit tracks the line. Captured bits are masked by an enable register. Software reads a vector register to learn the lowest-numbered line that is both captured and enabled. A two-bit master enable gates the request pin.

Software reaches the block through a plain 32-bit register port. The port has a byte address, a read strobe, a write strobe, write data and registered read data. There are eight word-spaced registers inside a 32-byte window. Writes complete in the strobe cycle. Read data appears one cycle after the read strobe and is held until the next read. The port has no back-pressure: every strobe is accepted in the cycle it is presented.

Top module: `intr_vector_ctrl`

## Requirements
- R1: After reset, the captured status, enable and master-enable registers are all zero and `irq_o` is low.
- R2: For an edge-kind line (bit set in `EDGE_KIND`), a rising transition sets its status bit. The bit is visible after the first clock edge that sees the line high. It stays set after the line falls, until acknowledged. An acknowledge while the line is still high leaves the bit clear until a new rising transition.
- R3: For a level-kind line, the status bit equals the line's value as sampled at the previous clock edge.
- R4: A write to offset 0x0C (acknowledge) clears the status bits where the write data has a 1 and leaves the other bits unchanged. A level line that is still high sets its bit again one cycle after the acknowledge.
- R5: A write to offset 0x08 loads the enable register directly. A write to 0x10 ORs the data into it. A write to 0x14 clears the enable bits where the data has a 1.
- R6: Reading offset 0x04 returns pending, which is status AND enable.
- R7: Reading offset 0x18 returns the index of the lowest-numbered pending line, zero-extended. It returns 0xFFFFFFFF when nothing is pending.
- R8: `irq_o` is high exactly when both bits of the master-enable register (offset 0x1C, bits 1:0) are 1 and pending is nonzero. Reading 0x1C returns those two bits.
- R9: Writes to offsets 0x00 (status), 0x04 and 0x18 change nothing. Reads of 0x0C, 0x10 and 0x14 return zero.
- R10: `bus_rdata` is loaded one clock after a cycle with `bus_rd` high. It keeps its value in every other cycle.
- R11: Only address bits 4:2 select the register. Bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Peripheral interrupt lines, line n maps to bit n |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A register write takes effect at the clock edge where the strobe is sampled. Status reacts to a line change at the first edge that samples it. `irq_o` is combinational from these registers, so the bench compares it at the falling edge after that clock edge. A read's data is due one edge after its strobe. The driver queues the expected word when it raises `bus_rd`, and the monitor compares it at the following falling edge. The case where a level line is re-armed after an acknowledge is timed so that the first read shows the cleared bit and the next read shows it set again.

// File: rtl/intr_vec_pkg.sv
package intr_vec_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFF_LSB = 2;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS  = 3'd0,
    SEL_PENDING = 3'd1,
    SEL_ENABLE  = 3'd2,
    SEL_ACK     = 3'd3,
    SEL_EN_SET  = 3'd4,
    SEL_EN_CLR  = 3'd5,
    SEL_VECTOR  = 3'd6,
    SEL_MASTER  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic load;
    logic set;
    logic clr;
    logic ack;
    logic master;
  } wr_ctl_t;

endpackage

// File: rtl/intr_capture.sv
module intr_capture #(
  parameter int unsigned N_SRC = 32,
  parameter logic [31:0] EDGE_KIND = 32'h0000_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] ack_mask_i,
  output logic [N_SRC-1:0] status_o
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_line
    if (EDGE_KIND[g]) begin : g_edge
      logic prev_q;
      logic rise;
      assign rise = src_i[g] & ~prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q      <= 1'b0;
          status_o[g] <= 1'b0;
        end else begin
          prev_q      <= src_i[g];
          status_o[g] <= (status_o[g] & ~ack_mask_i[g]) | rise;
        end
      end
    end else begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          status_o[g] <= 1'b0;
        end else begin
          status_o[g] <= ack_mask_i[g] ? 1'b0 : src_i[g];
        end
      end
    end
  end

endmodule

// File: rtl/intr_enable_reg.sv
module intr_enable_reg #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [N_SRC-1:0] data_i,
  output logic [N_SRC-1:0] en_o
);

  logic [N_SRC-1:0] en_next;

  always_comb begin
    en_next = en_o;
    if (load_i) en_next = data_i;
    if (set_i)  en_next = en_o | data_i;
    if (clr_i)  en_next = en_o & ~data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_o <= '0;
    else        en_o <= en_next;
  end

endmodule

// File: rtl/intr_lowest.sv
module intr_lowest #(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] pend_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |pend_i;

endmodule

// File: rtl/intr_vector_ctrl.sv
module intr_vector_ctrl
  import intr_vec_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  parameter logic [31:0] EDGE_KIND = 32'h0000_FFFF,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);

  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  reg_sel_e         sel;
  wr_ctl_t          wctl;
  logic [N_SRC-1:0] status_w;
  logic [N_SRC-1:0] en_w;
  logic [N_SRC-1:0] pend_w;
  logic [N_SRC-1:0] ack_mask;
  logic [1:0]       mer_q;
  logic             hit_w;
  logic [IDX_W-1:0] idx_w;
  logic [WORD_W-1:0] vec_word;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] rdata_q;
  logic             unused_addr;

  assign unused_addr = ^bus_addr[OFF_LSB-1:0];
  assign sel = reg_sel_e'(bus_addr[OFF_LSB+SEL_W-1:OFF_LSB]);

  always_comb begin
    wctl        = '0;
    wctl.load   = bus_wr && (sel == SEL_ENABLE);
    wctl.set    = bus_wr && (sel == SEL_EN_SET);
    wctl.clr    = bus_wr && (sel == SEL_EN_CLR);
    wctl.ack    = bus_wr && (sel == SEL_ACK);
    wctl.master = bus_wr && (sel == SEL_MASTER);
  end

  assign ack_mask = wctl.ack ? bus_wdata[N_SRC-1:0] : '0;

  intr_capture #(.N_SRC(N_SRC), .EDGE_KIND(EDGE_KIND)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .ack_mask_i(ack_mask),
    .status_o  (status_w)
  );

  intr_enable_reg #(.N_SRC(N_SRC)) u_enable (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(wctl.load),
    .set_i (wctl.set),
    .clr_i (wctl.clr),
    .data_i(bus_wdata[N_SRC-1:0]),
    .en_o  (en_w)
  );

  assign pend_w = status_w & en_w;

  intr_lowest #(.N_SRC(N_SRC)) u_lowest (
    .pend_i(pend_w),
    .hit_o (hit_w),
    .idx_o (idx_w)
  );

  assign vec_word = hit_w ? WORD_W'(idx_w) : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mer_q <= 2'b00;
    else if (wctl.master) mer_q <= bus_wdata[1:0];
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS:  rd_word = WORD_W'(status_w);
      SEL_PENDING: rd_word = WORD_W'(pend_w);
      SEL_ENABLE:  rd_word = WORD_W'(en_w);
      SEL_VECTOR:  rd_word = vec_word;
      SEL_MASTER:  rd_word = WORD_W'(mer_q);
      default:     rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_word;
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = (&mer_q) & hit_w;

endmodule

// File: rtl/intr_vector_chk.sv
module intr_vector_chk #(
  parameter int unsigned N_SRC = 32,
  parameter logic [31:0] EDGE_KIND = 32'h0000_FFFF,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  src_i,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq_o,
  input logic [N_SRC-1:0]  status_q,
  input logic [N_SRC-1:0]  enable_q,
  input logic [1:0]        mer_q
);

  logic ack_wr, sie_wr, cie_wr, vec_rd;
  assign ack_wr = bus_wr && (bus_addr[4:2] == 3'd3);
  assign sie_wr = bus_wr && (bus_addr[4:2] == 3'd4);
  assign cie_wr = bus_wr && (bus_addr[4:2] == 3'd5);
  assign vec_rd = bus_rd && (bus_addr[4:2] == 3'd6);

  AST_SET_EN_OR: assert property (@(posedge clk) disable iff (!rst_n)
    sie_wr |=> ((enable_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0]))); // R5

  AST_CLR_EN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    cie_wr |=> ((enable_q & $past(bus_wdata[N_SRC-1:0])) == '0)); // R5

  AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mer_q == 2'b11)); // R8

  AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && ((status_q & enable_q) == '0)) |=> (bus_rdata == 32'hFFFF_FFFF)); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R10

  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    if (EDGE_KIND[g]) begin : g_edge
      AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[g] && !(ack_wr && bus_wdata[g])) |=> status_q[g]); // R2
      AST_EDGE_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && bus_wdata[g] && !src_i[g]) |=> !status_q[g]); // R4
    end else begin : g_level
      AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_wr && bus_wdata[g]) |=> (status_q[g] == $past(src_i[g]))); // R3
      AST_LEVEL_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && bus_wdata[g]) |=> !status_q[g]); // R4
    end
  end

endmodule

bind intr_vector_ctrl intr_vector_chk #(
  .N_SRC(N_SRC), .EDGE_KIND(EDGE_KIND), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_i    (src_i),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq_o    (irq_o),
  .status_q (status_w),
  .enable_q (en_w),
  .mer_q    (mer_q)
);

// File: tb/test_intr_vector_ctrl.sv
module test_intr_vector_ctrl;

  localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_EN = 5'h08, A_ACK = 5'h0C;
  localparam logic [4:0] A_SET = 5'h10, A_CLR = 5'h14, A_VEC = 5'h18, A_MER = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  intr_vector_ctrl i_intr_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) chk("R10 unexpected read", bus_rdata, 32'h0);
        else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    rd(A_STAT, 32'h0, "R1 status reset");
    rd(A_EN, 32'h0, "R1 enable reset");
    rd(A_MER, 32'h0, "R1 master reset");
    rd(A_VEC, 32'hFFFF_FFFF, "R7 vector empty after reset");
    // R2 edge pulse on line 3 is latched
    src[3] = 1'b1; tick(); src[3] = 1'b0; tick(2);
    rd(A_STAT, 32'h0000_0008, "R2 edge latched after fall");
    rd(A_VEC, 32'hFFFF_FFFF, "R7 vector masked by enable");
    // R5 enable load, set, clear
    wr(A_EN, 32'h0001_0008);
    rd(A_EN, 32'h0001_0008, "R5 enable load");
    wr(A_SET, 32'h0000_0100);
    rd(A_EN, 32'h0001_0108, "R5 set-enable OR");
    wr(A_CLR, 32'h0000_0008);
    rd(A_EN, 32'h0001_0100, "R5 clear-enable");
    wr(A_SET, 32'h0000_0008);
    // R6, R7, R8
    rd(A_PEND, 32'h0000_0008, "R6 pending");
    rd(A_VEC, 32'h0000_0003, "R7 vector line 3");
    chk("R8 irq with master off", {31'b0, irq_o}, 32'h0);
    wr(A_MER, 32'h0000_0001);
    chk("R8 irq with one master bit", {31'b0, irq_o}, 32'h0);
    wr(A_MER, 32'hFFFF_FFFF);
    chk("R8 irq with master on", {31'b0, irq_o}, 32'h1);
    rd(A_MER, 32'h0000_0003, "R8 master readback");
    wr(A_MER, 32'h0000_0002);
    chk("R8 irq with bit0 clear", {31'b0, irq_o}, 32'h0);
    wr(A_MER, 32'h0000_0003);
    // R3, R4 level line 16
    src[16] = 1'b1; tick();
    rd(A_STAT, 32'h0001_0008, "R3 level captured");
    wr(A_ACK, 32'h0000_0008);
    rd(A_VEC, 32'h0000_0010, "R4 ack line 3 then vector 16");
    wr(A_ACK, 32'h0001_0000);
    rd(A_STAT, 32'h0000_0000, "R4 level cleared by ack");
    rd(A_STAT, 32'h0001_0000, "R4 level re-armed");
    src[16] = 1'b0; tick();
    rd(A_STAT, 32'h0000_0000, "R3 level follows low");
    chk("R8 irq off when nothing pending", {31'b0, irq_o}, 32'h0);
    rd(A_VEC, 32'hFFFF_FFFF, "R7 vector empty");
    // R9 ignored writes and zero reads
    src[4] = 1'b1; tick(); src[4] = 1'b0; tick();
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_PEND, 32'hFFFF_FFFF);
    wr(A_VEC, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h0000_0010, "R9 status write ignored");
    rd(A_EN, 32'h0001_0108, "R9 enable untouched");
    rd(A_ACK, 32'h0, "R9 ack reads zero");
    rd(A_SET, 32'h0, "R9 set reads zero");
    rd(A_CLR, 32'h0, "R9 clear reads zero");
    wr(A_ACK, 32'h0000_0010);
    // R2, R4 selective ack, line 1 held high
    src[1] = 1'b1; src[5] = 1'b1; tick(); src[5] = 1'b0;
    wr(A_SET, 32'h0000_0022);
    rd(A_PEND, 32'h0000_0022, "R6 pending two edges");
    rd(A_VEC, 32'h0000_0001, "R7 lowest of two");
    chk("R8 irq with pending", {31'b0, irq_o}, 32'h1);
    wr(A_ACK, 32'h0000_0002);
    rd(A_STAT, 32'h0000_0020, "R2 no re-trigger while high");
    rd(A_VEC, 32'h0000_0005, "R4 selective ack");
    // R10 hold
    wr(A_ACK, 32'h0000_0020);
    tick(3);
    chk("R10 rdata held", bus_rdata, 32'h0000_0005);
    chk("R4 irq after full ack", {31'b0, irq_o}, 32'h0);
    src[1] = 1'b0;
    // R11 low address bits ignored
    rd(5'h0B, 32'h0001_012A, "R11 misaligned enable read");
    tick(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule